// File: doc/BRIEF.md
# Interrupt Vector Fetch and Segment Restore

This block runs the entry into a reset or interrupt handler, and the return from it, for a core whose program counter sits inside a selectable code segment. A request arrives with a source index. The block turns the index into a location in the vector table at the bottom of segment 0. It reads the two vector bytes over a byte-wide program-memory read port and loads them into the program counter. It then clears the code segment register, so the handler always runs in segment 0.

When the memory model is medium or large, an interrupt entry first pushes the interrupted code segment onto the stack through a push/pop port. A later return-from-interrupt command pops it back, so execution resumes in the original segment. A reset entry never pushes anything. In the small model no segment is saved or restored. Source priority, and the saving of the program counter and flags, are handled elsewhere in the core.

Top module: `vec_entry_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc`, `csr`, `busy`, `done`, `mem_rd_en`, `stk_push` and `stk_pop` all become 0.
- R2: A source index below 37 selects the vector at byte offset 2*index. Indices 37 to 41 select offset 0x6A + 2*(index-37). The segment bits of `mem_addr` (bits 19:16) are 0 during every read. The low byte is read at the even offset, then the high byte at offset+1. `pc` becomes {high, low}.
- R3: In the cycle after `done`, `csr` reads 0 and `pc` holds the fetched vector.
- R4: When `model` is not 2'b00 and the index is not 0, the entry asserts `stk_push` for exactly one cycle, with `stk_wdata` equal to the code segment held at the request. This cycle comes before the first memory read.
- R5: In model 2'b00, or for index 0 (reset), there is no push. `busy` lasts 3 cycles and `done` is high in the third. An entry with a push keeps `busy` high for 4 cycles, with `done` high in the fourth.
- R6: `rti` accepted while idle, with `model` not 2'b00, asserts `stk_pop` for one cycle. In the next cycle `csr` equals the `stk_rdata` presented in the pop cycle. Nested entries restore in last-in-first-out order.
- R7: `rti` in model 2'b00 asserts no `stk_pop` and leaves `csr` unchanged.
- R8: A request made while `busy` is high, or one with an index of 42 or more, starts nothing. `busy` stays as it was, no read or push happens, and `pc` is unchanged.
- R9: `csr_ld` writes `csr_ld_val` into `csr` only when the block is idle and neither an accepted request nor `rti` is present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Reset/interrupt entry request |
| req_idx | input | 6 | Source index, 0 = reset |
| model | input | 2 | Memory model: 00 small, 01 medium, 10/11 large |
| rti | input | 1 | Return-from-interrupt command |
| csr_ld | input | 1 | Load code segment from the core (far transfer) |
| csr_ld_val | input | 4 | Value for `csr_ld` |
| mem_rd_en | output | 1 | Program-memory byte read strobe |
| mem_addr | output | 20 | Program-memory byte address |
| mem_rdata | input | 8 | Read byte, valid in the same cycle as the strobe |
| stk_push | output | 1 | Push code segment onto stack |
| stk_wdata | output | 4 | Pushed segment value |
| stk_pop | output | 1 | Pop code segment from stack |
| stk_rdata | input | 4 | Stack top, valid in the pop cycle |
| pc | output | 16 | Program counter loaded from the vector |
| csr | output | 4 | Code segment register |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse in the vector-load cycle |

## Verification
Entries are issued for indices at both ends of each table region (0, 5, 36, 37, 41), in all three memory models. This separates the two address regions and the off-by-one at the region seam. It also shows whether the push decision depends on the model or on the reset index. Entries are started from non-zero segments and nested twice before two returns, which exposes a missing push, a wrong pushed value or a broken restore order. Requests made while busy, out-of-range indices, small-model returns and segment loads that collide with `rti` each must leave the ports unchanged.

// File: rtl/vec_pkg.sv
// Package: shared types for the vector entry controller.
// Assumes: nothing beyond IEEE 1800-2017.
package vec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PUSH  = 3'd1,
        ST_RD_LO = 3'd2,
        ST_RD_HI = 3'd3,
        ST_LOAD  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        MM_SMALL  = 2'b00,
        MM_MEDIUM = 2'b01,
        MM_LARGE  = 2'b10,
        MM_LARGE2 = 2'b11
    } mem_model_t;

endpackage

// File: rtl/vec_addr_map.sv
// Module: vec_addr_map
// Maps a source index to the byte offset of its vector in segment 0.
// The table is two regions: N_LO entries from LO_BASE, then N_HI entries
// from HI_BASE. Each entry takes two bytes.
// Assumes: regions do not overlap and fit in OFS_W bits.
module vec_addr_map #(
    parameter int IDX_W   = 6,
    parameter int OFS_W   = 16,
    parameter int N_LO    = 37,
    parameter int N_HI    = 5,
    parameter int LO_BASE = 'h0000,
    parameter int HI_BASE = 'h006A
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OFS_W-1:0] ofs,
    output logic             idx_ok
);
    localparam int N_TOTAL = N_LO + N_HI;
    localparam logic [OFS_W-1:0] LO_B = OFS_W'(LO_BASE);
    localparam logic [OFS_W-1:0] HI_B = OFS_W'(HI_BASE);
    localparam logic [OFS_W-1:0] N_LO_W = OFS_W'(N_LO);

    logic [OFS_W-1:0] idx_w;
    assign idx_w = OFS_W'(idx);

    // Pick the region and form the even byte offset of the entry.
    always_comb begin
        idx_ok = (int'(idx) < N_TOTAL);
        if (int'(idx) < N_LO)
            ofs = LO_B + (idx_w << 1);
        else
            ofs = HI_B + ((idx_w - N_LO_W) << 1);
    end

endmodule

// File: rtl/vec_seq.sv
// Module: vec_seq
// Entry state machine: optional segment push, low byte read, high byte
// read, then load of the program counter with a done pulse.
// Assumes: mem_rdata is valid in the same cycle as mem_rd_en; the start
// inputs are only looked at while idle.
module vec_seq #(
    parameter int OFS_W  = 16,
    parameter int DATA_W = 8,
    localparam int PC_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              want_push,
    input  logic [OFS_W-1:0]  start_ofs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd_en,
    output logic [OFS_W-1:0]  mem_ofs,
    output logic              push_en,
    output logic              busy,
    output logic              done,
    output logic [PC_W-1:0]   pc
);
    import vec_pkg::*;

    seq_state_t        state_q, state_d;
    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;

    // Next-state choice for the entry sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = want_push ? ST_PUSH : ST_RD_LO;
            ST_PUSH:  state_d = ST_RD_LO;
            ST_RD_LO: state_d = ST_RD_HI;
            ST_RD_HI: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the table offset when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ofs_q <= '0;
        else if (state_q == ST_IDLE && start) ofs_q <= start_ofs;
    end

    // Capture the vector bytes as they are read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (state_q == ST_RD_LO) lo_q <= mem_rdata;
            if (state_q == ST_RD_HI) hi_q <= mem_rdata;
        end
    end

    // Program counter takes the assembled vector in the load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pc <= '0;
        else if (state_q == ST_LOAD) pc <= {hi_q, lo_q};
    end

    // Decode strobes and the read address from the state.
    always_comb begin
        mem_rd_en = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        mem_ofs   = (state_q == ST_RD_HI) ? (ofs_q + OFS_W'(1)) : ofs_q;
        push_en   = (state_q == ST_PUSH);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_LOAD);
    end

    // R2: the high byte read follows the low byte read at the next address.
    a_r2_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_ofs == $past(mem_ofs) + OFS_W'(1)));

    // R4: a push is always followed by the first vector read.
    a_r4_push_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> (mem_rd_en && !$past(mem_rd_en)));

    // R5: done ends the sequence.
    a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/seg_reg.sv
// Module: seg_reg
// Code segment register with three update sources in fixed priority:
// clear on vector load, restore from stack, load from the core.
// Assumes: the caller qualifies each enable; at most one matters per cycle.
module seg_reg #(
    parameter int SEG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             restore,
    input  logic [SEG_W-1:0] restore_val,
    input  logic             ld,
    input  logic [SEG_W-1:0] ld_val,
    output logic [SEG_W-1:0] seg
);

    // Update the segment by priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       seg <= '0;
        else if (clr)     seg <= '0;
        else if (restore) seg <= restore_val;
        else if (ld)      seg <= ld_val;
    end

endmodule

// File: rtl/vec_entry_ctl.sv
// Module: vec_entry_ctl (top)
// Reset/interrupt entry and return control for a segmented program
// counter. It fetches a two-byte vector from segment 0, clears the code
// segment, and saves/restores the segment on the stack outside the small
// memory model.
// Assumes: model is held stable during a sequence; the stack responds in
// the same cycle as the pop strobe.
module vec_entry_ctl #(
    parameter int IDX_W   = 6,
    parameter int OFS_W   = 16,
    parameter int SEG_W   = 4,
    parameter int DATA_W  = 8,
    parameter int N_LO    = 37,
    parameter int N_HI    = 5,
    parameter int LO_BASE = 'h0000,
    parameter int HI_BASE = 'h006A,
    localparam int ADDR_W = OFS_W + SEG_W,
    localparam int PC_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [1:0]        model,
    input  logic              rti,
    input  logic              csr_ld,
    input  logic [SEG_W-1:0]  csr_ld_val,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              stk_push,
    output logic [SEG_W-1:0]  stk_wdata,
    output logic              stk_pop,
    input  logic [SEG_W-1:0]  stk_rdata,
    output logic [PC_W-1:0]   pc,
    output logic [SEG_W-1:0]  csr,
    output logic              busy,
    output logic              done
);
    import vec_pkg::*;

    logic [OFS_W-1:0] map_ofs;
    logic             map_ok;
    logic [OFS_W-1:0] rd_ofs;
    logic             start;
    logic             saves_seg;
    logic             rti_take;
    logic             ld_take;

    vec_addr_map #(
        .IDX_W(IDX_W), .OFS_W(OFS_W), .N_LO(N_LO), .N_HI(N_HI),
        .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
    ) u_map (
        .idx    (req_idx),
        .ofs    (map_ofs),
        .idx_ok (map_ok)
    );

    // Accept decisions for the idle cycle.
    always_comb begin
        saves_seg = (mem_model_t'(model) != MM_SMALL);
        start     = !busy && req_valid && map_ok;
        rti_take  = !busy && !start && rti;
        ld_take   = !busy && !start && !rti && csr_ld;
    end

    vec_seq #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .want_push (saves_seg && (req_idx != '0)),
        .start_ofs (map_ofs),
        .mem_rdata (mem_rdata),
        .mem_rd_en (mem_rd_en),
        .mem_ofs   (rd_ofs),
        .push_en   (stk_push),
        .busy      (busy),
        .done      (done),
        .pc        (pc)
    );

    seg_reg #(.SEG_W(SEG_W)) u_seg (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (done),
        .restore     (stk_pop),
        .restore_val (stk_rdata),
        .ld          (ld_take),
        .ld_val      (csr_ld_val),
        .seg         (csr)
    );

    // Vector reads are always in segment 0; the push carries the live segment.
    always_comb begin
        mem_addr  = {{SEG_W{1'b0}}, rd_ofs};
        stk_wdata = csr;
        stk_pop   = rti_take && saves_seg;
    end

    // R2: reads never leave segment 0.
    a_r2_seg_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr[ADDR_W-1:OFS_W] == '0));

    // R3: the segment is zero after the vector load.
    a_r3_csr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (csr == '0));

    // R6: a pop restores the presented stack value.
    a_r6_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |=> (csr == $past(stk_rdata)));

    // R7: a pop never happens in the small model or during a sequence.
    a_r7_no_small_pop: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |-> (model != 2'b00 && !busy));

    // R4: stack and memory strobes are mutually exclusive.
    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stk_push, stk_pop, mem_rd_en}));

    // R8: the program counter moves only at the end of a sequence.
    a_r8_pc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> $stable(pc));

endmodule

// File: tb/tb_vec_entry_ctl.sv
module tb_vec_entry_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_idx = '0;
    logic [1:0]  model = 2'b00;
    logic        rti = 1'b0;
    logic        csr_ld = 1'b0;
    logic [3:0]  csr_ld_val = '0;
    logic        mem_rd_en;
    logic [19:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        stk_push;
    logic [3:0]  stk_wdata;
    logic        stk_pop;
    logic [3:0]  stk_rdata;
    logic [15:0] pc;
    logic [3:0]  csr;
    logic        busy;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vec_entry_ctl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .model(model), .rti(rti), .csr_ld(csr_ld), .csr_ld_val(csr_ld_val),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .stk_push(stk_push), .stk_wdata(stk_wdata), .stk_pop(stk_pop),
        .stk_rdata(stk_rdata), .pc(pc), .csr(csr), .busy(busy), .done(done)
    );

    // Program memory contents: a fixed function of the byte address.
    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return (a[7:0] * 8'd7 + 8'h3C) ^ a[15:8] ^ {a[19:16], 4'h0};
    endfunction
    assign mem_rdata = mem_byte(mem_addr);

    // Stack model.
    logic [3:0] stk_mem [0:15];
    logic [4:0] sp;
    assign stk_rdata = stk_mem[sp[3:0] - 4'd1];
    always @(posedge clk) begin
        if (!rst_n) sp <= '0;
        else if (stk_push) begin
            stk_mem[sp[3:0]] <= stk_wdata;
            sp <= sp + 5'd1;
        end else if (stk_pop) sp <= sp - 5'd1;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_ofs(input int idx);
        return (idx < 37) ? 16'(2 * idx) : 16'(16'h6A + 2 * (idx - 37));
    endfunction

    task automatic set_csr(input logic [3:0] v);
        @(negedge clk);
        csr_ld = 1'b1; csr_ld_val = v;
        @(negedge clk);
        csr_ld = 1'b0;
        chk(csr == v, "R9 csr load", csr, v);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc == 0 && csr == 0, "R1 pc/csr", {pc, csr}, 0);
        chk(!busy && !done && !mem_rd_en && !stk_push && !stk_pop, "R1 strobes",
            {busy, done, mem_rd_en, stk_push, stk_pop}, 0);
        rst_n = 1'b1;
    endtask

    // One entry; checks addresses, push, length, pc and csr.
    task automatic t_entry(input int idx, input logic [1:0] mdl, input string tag);
        logic [15:0] ofs = vec_ofs(idx);
        logic [15:0] exp_pc = {mem_byte({4'h0, ofs + 16'd1}), mem_byte({4'h0, ofs})};
        logic        exp_push = (mdl != 2'b00) && (idx != 0);
        logic [3:0]  seg0 = csr;
        int cyc = 1, pushes = 0, reads = 0;
        logic [3:0] pushed = '0;
        logic addr_ok = 1'b1;
        @(negedge clk);
        model = mdl; req_valid = 1'b1; req_idx = 6'(idx);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 10) begin
            if (stk_push) begin pushes++; pushed = stk_wdata; end
            if (mem_rd_en) begin
                if (mem_addr != {4'h0, ofs + 16'(reads)}) addr_ok = 1'b0;
                if (stk_push === 1'b0 && pushes != (exp_push ? 1 : 0)) addr_ok = 1'b0;
                reads++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(addr_ok && reads == 2, {"R2 addr ", tag}, reads, 2);
        chk(pushes == (exp_push ? 1 : 0), {"R4 push count ", tag}, pushes, exp_push);
        if (exp_push) chk(pushed == seg0, {"R4 push value ", tag}, pushed, seg0);
        chk(cyc == (exp_push ? 4 : 3), {"R5 length ", tag}, cyc, exp_push ? 4 : 3);
        @(negedge clk);
        chk(pc == exp_pc, {"R2 pc ", tag}, pc, exp_pc);
        chk(csr == 0 && !busy, {"R3 csr ", tag}, csr, 0);
    endtask

    task automatic t_rti(input logic [1:0] mdl, input logic [3:0] exp_csr, input string tag);
        logic saw_pop;
        @(negedge clk);
        model = mdl; rti = 1'b1;
        #1 saw_pop = stk_pop;
        @(negedge clk);
        rti = 1'b0;
        chk(saw_pop == (mdl != 2'b00), {"R6 pop strobe ", tag}, saw_pop, mdl != 2'b00);
        chk(csr == exp_csr, {"R6 R7 csr ", tag}, csr, exp_csr);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] exp_pc = {mem_byte(20'h00015), mem_byte(20'h00014)};
        @(negedge clk);
        model = 2'b00; req_valid = 1'b1; req_idx = 6'd10;
        @(negedge clk);
        req_idx = 6'd3;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(pc == exp_pc && !busy, "R8 busy ignore", pc, exp_pc);
    endtask

    task automatic t_bad_idx();
        logic [15:0] pc0 = pc;
        @(negedge clk);
        req_valid = 1'b1; req_idx = 6'd42;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!busy && !mem_rd_en && !stk_push, "R8 bad index", busy, 0);
        req_valid = 1'b1; req_idx = 6'd63;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(pc == pc0 && !busy, "R8 bad index pc", pc, pc0);
    endtask

    task automatic t_ld_vs_rti();
        @(negedge clk);
        model = 2'b00; rti = 1'b1; csr_ld = 1'b1; csr_ld_val = 4'hE;
        @(negedge clk);
        rti = 1'b0; csr_ld = 1'b0;
        chk(csr == 4'h7, "R9 ld blocked by rti", csr, 4'h7);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        set_csr(4'h5);
        t_entry(0, 2'b01, "reset idx medium");
        t_entry(5, 2'b00, "small");
        t_entry(36, 2'b00, "last low");
        t_entry(37, 2'b00, "first high");
        t_entry(41, 2'b00, "last high");
        set_csr(4'h9);
        t_entry(12, 2'b01, "medium");
        t_rti(2'b01, 4'h9, "medium");
        set_csr(4'h3);
        t_entry(20, 2'b10, "large outer");
        set_csr(4'h6);
        t_entry(38, 2'b11, "large inner");
        t_rti(2'b10, 4'h6, "inner");
        t_rti(2'b10, 4'h3, "outer");
        set_csr(4'h7);
        t_rti(2'b00, 4'h7, "small R7");
        t_ld_vs_rti();
        t_busy_ignore();
        t_bad_idx();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule